// File: doc/BRIEF.md
# Add-Compare-Select State Metric Unit

This block is the metric core of a Viterbi decoder for a rate 1/2, constraint length 7 feed-forward convolutional code with octal generators 171 and 133. It holds one path metric for each of the 64 trellis states. On every cycle with `in_valid` high it takes four branch metrics, one for each possible two-bit code symbol. For every state it adds the matching branch metric to the metrics of the state's two predecessors, keeps the smaller sum, and records which predecessor won. The 64 survivor decision bits and the index of the state with the smallest new metric are registered and leave the block one cycle later with the `out_valid` strobe. They feed a traceback unit that is not part of this block.

Metrics carry over from symbol to symbol in continuous operation. After every update they are normalised by subtracting the minimum metric of the previous step, so they never wrap. A decoder reset (`dec_rst`) loads the initial metric set: state 0 gets zero and every other state gets the all-ones maximum. `rst_defer` selects when that load happens. When it is low, the reset applies before the symbol of the same cycle. When it is high, the current symbol is first processed against the old metrics and the initial set is loaded afterwards.

A two-state controller sequences deferred resets. In `ST_LIVE` no reset is pending. A deferred reset that arrives without a symbol moves the controller to `ST_ARMED` (transition *arm*). The next valid symbol returns it to `ST_LIVE` after that symbol has been processed and the metrics have been reloaded (transition *release*). An immediate reset while in `ST_ARMED` also returns the controller to `ST_LIVE` (transition *cancel*).

Top module: `acs_metric_unit`

## Requirements
- R1: On an active-low `rst_n`, `out_valid`, `dec_out` and `best_state` are 0, state 0 holds metric 0 and every other state holds the all-ones maximum. A first symbol with branch metric 5 for symbol 0 and 2 for symbol 3 therefore yields `best_state` 32.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R3: State s has predecessors {s[4:0],0} (even) and {s[4:0],1} (odd), and the bit that entered the encoder is s[5]. The code symbol of a branch is 2*g0+g1, where g0 and g1 are the parities of the 7-bit register {input, predecessor[5:0]} masked with 171 and 133 octal. The branch metric for symbol k sits in `bm_in[8k+7:8k]`.
- R4: Each candidate is the predecessor metric plus its branch metric, saturated at 65535. `dec_out[s]` is 1 only when the odd predecessor's candidate is strictly smaller, so a tie gives 0.
- R5: The new metric of a state is the winning candidate minus the minimum metric of the previous step. `best_state` is the index of the smallest new metric, and the lowest index wins a tie.
- R6: Cycles with `in_valid` low leave the metrics, `dec_out` and `best_state` unchanged.
- R7: With `rst_defer` low, `dec_rst` loads the initial metrics before any symbol of the same cycle is processed.
- R8: With `rst_defer` high, a symbol that arrives together with `dec_rst` is processed against the old metrics, and the initial metrics are loaded after it.
- R9: A deferred reset that arrives without a symbol stays pending. The next valid symbol is processed against the old metrics and then the initial metrics are loaded. An immediate reset supersedes the pending one.
- R10: The stored minimum metric never exceeds the largest branch metric (255), so the metrics never wrap, even under sustained maximal branch metrics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A symbol's branch metrics are present |
| bm_in | input | 32 | Four 8-bit branch metrics; field k is for code symbol k |
| dec_rst | input | 1 | Decoder reset request |
| rst_defer | input | 1 | 1: apply reset after the current symbol; 0: before it |
| out_valid | output | 1 | Registered results are fresh |
| dec_out | output | 64 | Survivor decision per state (1 = odd predecessor) |
| best_state | output | 6 | Index of the state with the smallest new metric |

## Verification
The bench aims at the ordering of reset against the symbol in the same cycle. A design that swapped the immediate and deferred paths would report state 32 as best where the old metrics should have decided, or the reverse. The bench holds a deferred reset across idle cycles. A design that dropped the pending reset, or applied it at once, would then diverge from the reference on the following symbols. The bench also drives equal candidates, where a strict-versus-non-strict compare error flips decision bits or moves `best_state` off the lowest index. Long runs of near-maximal branch metrics expose a missing saturation or a normalisation that subtracts the wrong minimum, because the metrics wrap and the survivors go wrong.

// File: rtl/acs_pkg.sv
package acs_pkg;

    typedef enum logic {
        ST_LIVE  = 1'b0,
        ST_ARMED = 1'b1
    } rst_state_t;

    function automatic int unsigned tap_parity(input int unsigned v,
                                               input int unsigned taps);
        int unsigned x;
        int unsigned p;
        x = v & taps;
        p = 0;
        for (int i = 0; i < 32; i++) begin
            p = p ^ ((x >> i) & 1);
        end
        return p;
    endfunction

    // code symbol index: upper generator parity in bit 1, lower in bit 0
    function automatic int unsigned branch_sym(input int unsigned prev,
                                               input int unsigned u,
                                               input int unsigned k,
                                               input int unsigned g_up,
                                               input int unsigned g_lo);
        int unsigned r;
        r = (u << (k - 1)) | prev;
        return (tap_parity(r, g_up) << 1) | tap_parity(r, g_lo);
    endfunction

endpackage

// File: rtl/acs_node.sv
module acs_node #(
    parameter int W   = 16,
    parameter int BMW = 8
) (
    input  logic [W-1:0]   m_even,
    input  logic [W-1:0]   m_odd,
    input  logic [BMW-1:0] bm_even,
    input  logic [BMW-1:0] bm_odd,
    input  logic [W-1:0]   norm,
    output logic [W-1:0]   m_next,
    output logic           dec
);
    localparam logic [W-1:0] SAT = '1;

    logic [W:0]   sum_e, sum_o;
    logic [W-1:0] cand_e, cand_o, win;

    always_comb begin
        sum_e  = {1'b0, m_even} + {{(W+1-BMW){1'b0}}, bm_even};
        sum_o  = {1'b0, m_odd}  + {{(W+1-BMW){1'b0}}, bm_odd};
        cand_e = sum_e[W] ? SAT : sum_e[W-1:0];
        cand_o = sum_o[W] ? SAT : sum_o[W-1:0];
        dec    = (cand_o < cand_e);
        win    = dec ? cand_o : cand_e;
        m_next = win - norm;
    end

endmodule

// File: rtl/acs_min_tree.sv
module acs_min_tree #(
    parameter int N  = 64,
    parameter int W  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [W-1:0]  vals [N],
    output logic [IW-1:0] min_idx,
    output logic [W-1:0]  min_val
);
    logic [W-1:0]  tv [0:IW][0:N-1];
    logic [IW-1:0] ti [0:IW][0:N-1];

    always_comb begin
        for (int l = 0; l <= IW; l++) begin
            for (int i = 0; i < N; i++) begin
                tv[l][i] = '0;
                ti[l][i] = '0;
            end
        end
        for (int i = 0; i < N; i++) begin
            tv[0][i] = vals[i];
            ti[0][i] = IW'(i);
        end
        for (int l = 0; l < IW; l++) begin
            for (int i = 0; i < (N >> (l + 1)); i++) begin
                // left operand carries the lower index and keeps ties
                if (tv[l][2*i+1] < tv[l][2*i]) begin
                    tv[l+1][i] = tv[l][2*i+1];
                    ti[l+1][i] = ti[l][2*i+1];
                end else begin
                    tv[l+1][i] = tv[l][2*i];
                    ti[l+1][i] = ti[l][2*i];
                end
            end
        end
        min_val = tv[IW][0];
        min_idx = ti[IW][0];
    end

endmodule

// File: rtl/acs_rst_ctl.sv
module acs_rst_ctl
    import acs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic dec_rst,
    input  logic rst_defer,
    output logic pre_init,
    output logic post_init
);
    rst_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LIVE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LIVE: begin
                if (dec_rst && rst_defer && !in_valid) st_d = ST_ARMED;   // arm
            end
            ST_ARMED: begin
                if (dec_rst && !rst_defer)  st_d = ST_LIVE;               // cancel
                else if (in_valid)          st_d = ST_LIVE;               // release
            end
            default: st_d = ST_LIVE;
        endcase
    end

    always_comb begin
        pre_init  = dec_rst && !rst_defer;
        post_init = in_valid && !pre_init &&
                    ((st_q == ST_ARMED) || (dec_rst && rst_defer));
    end

    // R9: a pending reset is consumed by the next symbol
    p_armed_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && in_valid) |=> (st_q == ST_LIVE));

    // R9: an idle deferred reset request leaves a pending reset behind
    p_arm_on_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rst && rst_defer && !in_valid) |=> (st_q == ST_ARMED));

endmodule

// File: rtl/acs_metric_unit.sv
module acs_metric_unit
    import acs_pkg::*;
#(
    parameter int K       = 7,
    parameter int W       = 16,
    parameter int BMW     = 8,
    parameter int G_UPPER = 'o171,
    parameter int G_LOWER = 'o133
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [4*BMW-1:0]          bm_in,
    input  logic                      dec_rst,
    input  logic                      rst_defer,
    output logic                      out_valid,
    output logic [(1<<(K-1))-1:0]     dec_out,
    output logic [K-2:0]              best_state
);
    localparam int SW = K - 1;
    localparam int NS = 1 << SW;
    localparam logic [W-1:0] MAX_M  = '1;
    localparam logic [W-1:0] BM_TOP = W'((1 << BMW) - 1);

    logic [W-1:0]  metric_q [NS];
    logic [W-1:0]  src_m    [NS];
    logic [W-1:0]  m_next   [NS];
    logic [W-1:0]  min_q, src_min, best_val;
    logic [NS-1:0] dec_next;
    logic [SW-1:0] best_idx;
    logic          pre_init, post_init;

    acs_rst_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .dec_rst  (dec_rst),
        .rst_defer(rst_defer),
        .pre_init (pre_init),
        .post_init(post_init)
    );

    // source metrics: an immediate reset replaces them with the initial set
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            if (pre_init) src_m[s] = (s == 0) ? '0 : MAX_M;
            else          src_m[s] = metric_q[s];
        end
        src_min = pre_init ? '0 : min_q;
    end

    for (genvar s = 0; s < NS; s++) begin : g_state
        localparam int PE = (s << 1) & (NS - 1);
        localparam int PO = PE + 1;
        localparam int UB = s >> (SW - 1);
        localparam int SE = branch_sym(PE, UB, K, G_UPPER, G_LOWER);
        localparam int SO = branch_sym(PO, UB, K, G_UPPER, G_LOWER);

        acs_node #(.W(W), .BMW(BMW)) u_node (
            .m_even (src_m[PE]),
            .m_odd  (src_m[PO]),
            .bm_even(bm_in[SE*BMW +: BMW]),
            .bm_odd (bm_in[SO*BMW +: BMW]),
            .norm   (src_min),
            .m_next (m_next[s]),
            .dec    (dec_next[s])
        );
    end

    acs_min_tree #(.N(NS), .W(W), .IW(SW)) u_min (
        .vals   (m_next),
        .min_idx(best_idx),
        .min_val(best_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) metric_q[s] <= (s == 0) ? '0 : MAX_M;
            min_q <= '0;
        end else if (post_init || (pre_init && !in_valid)) begin
            for (int s = 0; s < NS; s++) metric_q[s] <= (s == 0) ? '0 : MAX_M;
            min_q <= '0;
        end else if (in_valid) begin
            for (int s = 0; s < NS; s++) metric_q[s] <= m_next[s];
            min_q <= best_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            dec_out    <= '0;
            best_state <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dec_out    <= dec_next;
                best_state <= best_idx;
            end
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dec_out) && $stable(best_state)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        min_q <= BM_TOP);

    p_init_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_init && !in_valid) |=>
            (metric_q[0] == '0 && metric_q[NS-1] == MAX_M));

endmodule

// File: tb/acs_metric_unit_bench.sv
`timescale 1ns/1ps
module acs_metric_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] bm_in = '0;
    logic        dec_rst = 1'b0;
    logic        rst_defer = 1'b0;
    logic        out_valid;
    logic [63:0] dec_out;
    logic [5:0]  best_state;

    acs_metric_unit u_acs_metric_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bm_in     (bm_in),
        .dec_rst   (dec_rst),
        .rst_defer (rst_defer),
        .out_valid (out_valid),
        .dec_out   (dec_out),
        .best_state(best_state)
    );

    always #4 clk = ~clk;

    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    int unsigned mm [64];
    int unsigned mmin;
    bit          armed_m;
    logic [63:0] exp_dec, last_dec;
    logic [5:0]  exp_best, last_best;

    localparam logic [31:0] BM_INIT = {8'd2, 8'd0, 8'd0, 8'd5};

    function automatic logic [1:0] ref_sym(input int p, input int u);
        logic [6:0] r;
        r = 7'((u << 6) | p);
        return {^(r & 7'o171), ^(r & 7'o133)};
    endfunction

    task automatic model_init();
        for (int s = 0; s < 64; s++) mm[s] = (s == 0) ? 0 : 65535;
        mmin = 0;
    endtask

    task automatic model_update(input logic [31:0] bmv, input bit from_init);
        int unsigned src [64];
        int unsigned nm [64];
        int unsigned smin, ce, co;
        for (int s = 0; s < 64; s++) src[s] = from_init ? ((s == 0) ? 0 : 65535) : mm[s];
        smin = from_init ? 0 : mmin;
        for (int s = 0; s < 64; s++) begin
            int pe, po, u;
            u  = s >> 5;
            pe = (s << 1) & 63;
            po = pe + 1;
            ce = src[pe] + int'(bmv[8*ref_sym(pe, u) +: 8]);
            co = src[po] + int'(bmv[8*ref_sym(po, u) +: 8]);
            if (ce > 65535) ce = 65535;
            if (co > 65535) co = 65535;
            exp_dec[s] = (co < ce);
            nm[s] = ((co < ce) ? co : ce) - smin;
        end
        exp_best = 6'd0;
        for (int s = 1; s < 64; s++) if (nm[s] < nm[exp_best]) exp_best = 6'(s);
        for (int s = 0; s < 64; s++) mm[s] = nm[s];
        mmin = nm[exp_best];
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit v, input logic [31:0] bmv, input bit r,
                        input bit d, input string tag);
        bit pre, post;
        in_valid = v; bm_in = bmv; dec_rst = r; rst_defer = d;
        pre = r && !d;
        if (pre) armed_m = 0;
        if (v) begin
            model_update(bmv, pre);
            post = armed_m || (r && d);
            if (post) begin
                model_init();
                armed_m = 0;
            end
        end else if (pre) begin
            model_init();
        end else if (r && d) begin
            armed_m = 1;
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid == v, "R2 out_valid", 64'(out_valid), 64'(v));
        if (v) begin
            check(dec_out == exp_dec, {tag, " decisions (R3/R4)"}, dec_out, exp_dec);
            check(best_state == exp_best, {tag, " best state (R5)"}, 64'(best_state), 64'(exp_best));
        end else begin
            check(dec_out == last_dec, "R6 idle decisions", dec_out, last_dec);
            check(best_state == last_best, "R6 idle best", 64'(best_state), 64'(last_best));
        end
        last_dec  = dec_out;
        last_best = best_state;
    endtask

    task automatic rand_steps(input int n, input bit allow_rst, input string tag);
        for (int i = 0; i < n; i++) begin
            bit v, r, d;
            v = ($urandom % 4) != 0;
            r = allow_rst && (($urandom % 24) == 0);
            d = $urandom % 2;
            step(v, $urandom, r, d, tag);
        end
    endtask

    initial begin
        repeat (2000000 / 8) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_init();
        armed_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);
        check(dec_out == '0, "R1 reset decisions", dec_out, 64'd0);
        check(best_state == '0, "R1 reset best", 64'(best_state), 64'd0);
        rst_n = 1'b1;
        last_dec = dec_out;
        last_best = best_state;

        // initial metrics visible through the first symbol
        step(1, BM_INIT, 0, 0, "R1");
        check(best_state == 6'd32, "R1 first best", 64'(best_state), 64'd32);
        check(dec_out == '0, "R4 tie on saturated preds", dec_out, 64'd0);

        rand_steps(60, 0, "R3");

        // immediate reset with a symbol in the same cycle
        step(1, BM_INIT, 1, 0, "R7");
        check(best_state == 6'd32, "R7 immediate reset", 64'(best_state), 64'd32);

        // equal candidates from the initial set: lowest index wins
        step(1, {8'd7, 8'd7, 8'd7, 8'd7}, 1, 0, "R5");
        check(best_state == 6'd0, "R5 tie lowest index", 64'(best_state), 64'd0);

        rand_steps(30, 0, "R3");

        // deferred reset with a symbol: old metrics decide, then reload
        step(1, $urandom, 1, 1, "R8");
        step(1, BM_INIT, 0, 0, "R8");
        check(best_state == 6'd32, "R8 reload after symbol", 64'(best_state), 64'd32);

        rand_steps(30, 0, "R3");

        // deferred reset on an idle cycle stays pending over idle cycles
        step(0, $urandom, 1, 1, "R9");
        step(0, $urandom, 0, 1, "R9");
        step(0, $urandom, 0, 0, "R9");
        step(1, $urandom, 0, 0, "R9");
        step(1, BM_INIT, 0, 0, "R9");
        check(best_state == 6'd32, "R9 pending reset applied", 64'(best_state), 64'd32);

        // pending reset superseded by an immediate one
        rand_steps(10, 0, "R3");
        step(0, $urandom, 1, 1, "R9");
        step(0, $urandom, 1, 0, "R9");
        step(1, BM_INIT, 0, 0, "R9");
        check(best_state == 6'd32, "R9 cancel", 64'(best_state), 64'd32);

        // immediate reset on an idle cycle
        rand_steps(10, 0, "R3");
        step(0, $urandom, 1, 0, "R7");
        step(1, BM_INIT, 0, 0, "R7");
        check(best_state == 6'd32, "R7 idle reset", 64'(best_state), 64'd32);

        // sustained large branch metrics stress saturation and normalisation
        for (int i = 0; i < 400; i++) begin
            logic [31:0] b;
            b = {8'(200 + $urandom % 56), 8'(200 + $urandom % 56),
                 8'(200 + $urandom % 56), 8'(200 + $urandom % 56)};
            step(1, b, 0, 0, "R10");
        end

        rand_steps(3000, 1, "R6");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule